// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small stored-program processor built around a single 16-bit accumulator. A program counter, an instruction register and the accumulator are its only architectural state. Instructions and data share one synchronous single-port memory of 4096 words. Each 16-bit instruction holds a 4-bit operation code in its top hex digit. The low 12 bits hold an address or an immediate value.

The core runs as a multi-cycle state machine. Every instruction first goes through a fetch cycle and a latch cycle, then an execute cycle. Instructions that go through a pointer take one more cycle, and instructions that combine a memory operand with the accumulator also take one more. A memory read issued in one cycle returns its data in the next. Once it executes a halt word, the core raises `halted` and makes no further memory access until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, the core issues a read of address 0 (`mem_rd`=1, `mem_addr`=0, `mem_wr`=0, `halted`=0). Reset clears the accumulator to zero.
- R2: The instruction word 0x0000 raises `halted`. From then until reset, `halted` stays 1 and `mem_rd` and `mem_wr` stay 0, so no later instruction takes effect.
- R3: The instruction word 0x0001 replaces the accumulator with its two's-complement negation, modulo 2^16 (0x8000 maps to itself and 0 to 0).
- R4: Opcode 0x1 sign-extends its 12-bit field from bit 11 and loads the result into the accumulator.
- R5: Opcode 0x2 loads mem[a] into the accumulator. Opcode 0x4 writes the accumulator to mem[a], and a read and a write are never issued in the same cycle.
- R6: Opcode 0x3 loads mem[p] into the accumulator, where p is the low 12 bits of mem[a].
- R7: Opcode 0x5 writes the accumulator to mem[p], where p is the low 12 bits of mem[a]. The pointer word itself is left unchanged.
- R8: Opcode 0x6 always continues execution at the absolute 12-bit address a.
- R9: Opcode 0x7 jumps to a when the accumulator is zero and otherwise falls through to the next word.
- R10: Opcode 0x8 jumps to a when bit 15 of the accumulator is clear and the accumulator is nonzero, and otherwise falls through.
- R11: Opcode 0x9 jumps to a when bit 15 of the accumulator is set, and otherwise falls through.
- R12: Opcode 0xA adds mem[a] to the accumulator, modulo 2^16.
- R13: Opcode 0xD replaces the accumulator with its bitwise AND with mem[a].
- R14: Opcodes 0xB, 0xC, 0xE and 0xF, and opcode 0x0 with an operand other than 0 or 1, change neither the accumulator nor memory. Execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rd | output | 1 | Read strobe; data returns on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_addr | output | 12 | Word address for the current access |
| mem_wdata | output | 16 | Store data (the accumulator) |
| mem_rdata | input | 16 | Read data from the access of the previous cycle |
| halted | output | 1 | High once a halt word has executed, until reset |

## Verification
The bench builds the core with its default 16-bit data width, which gives a 12-bit address field and a 4096-word memory model in the bench. With that width the sign boundaries at 0x7FFF, 0x8000 and 0xFFFF can be used directly as branch and arithmetic operands, so the zero, positive and negative tests each see both of their outcomes. Bit 11 of the immediate field is where sign extension starts, and pointer words can carry set upper bits that the core must discard.

// File: rtl/acc_cpu_pkg.sv
// Shared types for the accumulator processor core.
// Assumes a fixed 4-bit operation code in the top bits of each instruction word.
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    // Operation codes (top hex digit of an instruction word)
    localparam logic [OPC_W-1:0] OPC_SYS = 4'h0;
    localparam logic [OPC_W-1:0] OPC_LDI = 4'h1;
    localparam logic [OPC_W-1:0] OPC_LDD = 4'h2;
    localparam logic [OPC_W-1:0] OPC_LDN = 4'h3;
    localparam logic [OPC_W-1:0] OPC_STD = 4'h4;
    localparam logic [OPC_W-1:0] OPC_STN = 4'h5;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'h6;
    localparam logic [OPC_W-1:0] OPC_JZ  = 4'h7;
    localparam logic [OPC_W-1:0] OPC_JP  = 4'h8;
    localparam logic [OPC_W-1:0] OPC_JN  = 4'h9;
    localparam logic [OPC_W-1:0] OPC_ADD = 4'hA;
    localparam logic [OPC_W-1:0] OPC_AND = 4'hD;

    typedef enum logic [2:0] {
        ALU_PASS,
        ALU_NEG,
        ALU_IMM,
        ALU_ADD,
        ALU_AND
    } alu_op_e;

    typedef enum logic [1:0] {
        CND_ALWAYS,
        CND_ZERO,
        CND_POS,
        CND_NEG
    } cond_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_LATCH,
        ST_EXEC,
        ST_INDIR,
        ST_OPER,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        ASEL_PC,
        ASEL_IR,
        ASEL_PTR
    } addr_sel_e;

    typedef struct packed {
        logic    halt;
        logic    neg;
        logic    ldi;
        logic    rd;
        logic    wr;
        logic    ind;
        logic    branch;
        logic    undef;
        alu_op_e aluop;
        cond_e   cond;
    } dec_t;

endpackage

// File: rtl/acc_cpu_decode.sv
// Instruction decoder: turns the instruction register into control flags.
// Purely combinational. Assumes the opcode sits in the top OPC_W bits.
module acc_cpu_decode
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = DATA_W - OPC_W
) (
    input  logic [DATA_W-1:0] ir,
    output dec_t              dec
);

    logic [OPC_W-1:0]  opc;
    logic [ADDR_W-1:0] field;

    assign opc   = ir[DATA_W-1 -: OPC_W];
    assign field = ir[ADDR_W-1:0];

    // Map each opcode to the flags the controller and ALU need
    always_comb begin
        dec        = '0;
        dec.aluop  = ALU_PASS;
        dec.cond   = CND_ALWAYS;
        case (opc)
            OPC_SYS: begin
                if (field == '0) begin
                    dec.halt = 1'b1;
                end else if (field == ADDR_W'(1)) begin
                    dec.neg   = 1'b1;
                    dec.aluop = ALU_NEG;
                end else begin
                    dec.undef = 1'b1;
                end
            end
            OPC_LDI: begin
                dec.ldi   = 1'b1;
                dec.aluop = ALU_IMM;
            end
            OPC_LDD: dec.rd = 1'b1;
            OPC_LDN: begin
                dec.rd  = 1'b1;
                dec.ind = 1'b1;
            end
            OPC_STD: dec.wr = 1'b1;
            OPC_STN: begin
                dec.wr  = 1'b1;
                dec.ind = 1'b1;
            end
            OPC_JMP: dec.branch = 1'b1;
            OPC_JZ: begin
                dec.branch = 1'b1;
                dec.cond   = CND_ZERO;
            end
            OPC_JP: begin
                dec.branch = 1'b1;
                dec.cond   = CND_POS;
            end
            OPC_JN: begin
                dec.branch = 1'b1;
                dec.cond   = CND_NEG;
            end
            OPC_ADD: begin
                dec.rd    = 1'b1;
                dec.aluop = ALU_ADD;
            end
            OPC_AND: begin
                dec.rd    = 1'b1;
                dec.aluop = ALU_AND;
            end
            default: dec.undef = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_cpu_alu.sv
// Accumulator ALU and branch condition evaluation.
// Combinational. Assumes DATA_W > ADDR_W so the immediate can be sign-extended.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  logic [ADDR_W-1:0] imm,
    input  alu_op_e           aluop,
    input  cond_e             cond,
    output logic [DATA_W-1:0] result,
    output logic              take
);

    localparam int EXT_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] imm_ext;
    logic              acc_zero;
    logic              acc_neg;
    logic              acc_pos;

    assign imm_ext  = {{EXT_W{imm[ADDR_W-1]}}, imm};
    assign acc_zero = (acc == '0);
    assign acc_neg  = acc[DATA_W-1];
    assign acc_pos  = !acc_neg && !acc_zero;

    // Compute the accumulator's next value for the selected operation
    always_comb begin
        case (aluop)
            ALU_NEG:  result = '0 - acc;
            ALU_IMM:  result = imm_ext;
            ALU_ADD:  result = acc + operand;
            ALU_AND:  result = acc & operand;
            default:  result = operand;
        endcase
    end

    // Decide whether a branch is taken from the accumulator sign and zero tests
    always_comb begin
        case (cond)
            CND_ZERO: take = acc_zero;
            CND_POS:  take = acc_pos;
            CND_NEG:  take = acc_neg;
            default:  take = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
// Multi-cycle control state machine for the accumulator core.
// Assumes memory returns read data one cycle after the read strobe.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dec_t      dec,
    input  logic      take,
    output state_e    state,
    output logic      mem_rd,
    output logic      mem_wr,
    output addr_sel_e addr_sel,
    output logic      ld_ir,
    output logic      pc_inc,
    output logic      pc_br,
    output logic      acc_we,
    output logic      halted
);

    state_e state_q;
    state_e state_d;

    assign state  = state_q;
    assign halted = (state_q == ST_HALT);

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-state control strobes
    always_comb begin
        state_d  = state_q;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        addr_sel = ASEL_PC;
        ld_ir    = 1'b0;
        pc_inc   = 1'b0;
        pc_br    = 1'b0;
        acc_we   = 1'b0;
        case (state_q)
            ST_FETCH: begin
                mem_rd  = 1'b1;
                state_d = ST_LATCH;
            end
            ST_LATCH: begin
                ld_ir   = 1'b1;
                pc_inc  = 1'b1;
                state_d = ST_EXEC;
            end
            ST_EXEC: begin
                state_d = ST_FETCH;
                if (dec.halt) begin
                    state_d = ST_HALT;
                end else if (dec.neg || dec.ldi) begin
                    acc_we = 1'b1;
                end else if (dec.branch) begin
                    pc_br = take;
                end else if (dec.rd) begin
                    mem_rd   = 1'b1;
                    addr_sel = ASEL_IR;
                    state_d  = dec.ind ? ST_INDIR : ST_OPER;
                end else if (dec.wr) begin
                    addr_sel = ASEL_IR;
                    if (dec.ind) begin
                        mem_rd  = 1'b1;
                        state_d = ST_INDIR;
                    end else begin
                        mem_wr = 1'b1;
                    end
                end
            end
            ST_INDIR: begin
                addr_sel = ASEL_PTR;
                if (dec.wr) begin
                    mem_wr  = 1'b1;
                    state_d = ST_FETCH;
                end else begin
                    mem_rd  = 1'b1;
                    state_d = ST_OPER;
                end
            end
            ST_OPER: begin
                acc_we  = 1'b1;
                state_d = ST_FETCH;
            end
            default: state_d = ST_HALT;
        endcase
    end

    AST_OPER_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPER) |-> $past(mem_rd)); // R6
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R2

endmodule

// File: rtl/acc_cpu_core.sv
// Accumulator processor core top: PC, IR and ACC registers plus memory address mux.
// Assumes one synchronous memory with one-cycle read latency shared by code and data.
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic [DATA_W-OPC_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      halted
);

    localparam int ADDR_W = DATA_W - OPC_W;
    localparam logic [DATA_W-1:0] ACC_ZERO = '0;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] alu_result;
    logic              take;
    dec_t              dec;
    state_e            state;
    addr_sel_e         addr_sel;
    logic              ld_ir;
    logic              pc_inc;
    logic              pc_br;
    logic              acc_we;

    acc_cpu_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .ir  (ir_q),
        .dec (dec)
    );

    acc_cpu_alu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_alu (
        .acc     (acc_q),
        .operand (mem_rdata),
        .imm     (ir_q[ADDR_W-1:0]),
        .aluop   (dec.aluop),
        .cond    (dec.cond),
        .result  (alu_result),
        .take    (take)
    );

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec      (dec),
        .take     (take),
        .state    (state),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .addr_sel (addr_sel),
        .ld_ir    (ld_ir),
        .pc_inc   (pc_inc),
        .pc_br    (pc_br),
        .acc_we   (acc_we),
        .halted   (halted)
    );

    assign mem_wdata = acc_q;

    // Select the memory address: program counter, instruction field or fetched pointer
    always_comb begin
        case (addr_sel)
            ASEL_IR:  mem_addr = ir_q[ADDR_W-1:0];
            ASEL_PTR: mem_addr = mem_rdata[ADDR_W-1:0];
            default:  mem_addr = pc_q;
        endcase
    end

    // Program counter: cleared on reset, loaded on a taken branch, stepped after fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (pc_br) begin
            pc_q <= ir_q[ADDR_W-1:0];
        end else if (pc_inc) begin
            pc_q <= pc_q + ADDR_W'(1);
        end
    end

    // Instruction register: captures the fetched word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ld_ir) begin
            ir_q <= mem_rdata;
        end
    end

    // Accumulator: cleared on reset, written with the ALU result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_we) begin
            acc_q <= alu_result;
        end
    end

    AST_RESET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mem_rd && !mem_wr && mem_addr == '0 && !halted)); // R1
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr)); // R2
    AST_NEG_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && dec.neg) |=> (acc_q == ACC_ZERO - $past(acc_q))); // R3
    AST_IMM_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && dec.ldi) |=>
        (acc_q[ADDR_W-1:0] == $past(ir_q[ADDR_W-1:0]) &&
         ($past(ir_q[ADDR_W-1]) ? (&acc_q[DATA_W-1:ADDR_W-1]) : !(|acc_q[DATA_W-1:ADDR_W-1])))); // R4
    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R5
    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && dec.branch && take) |=> (pc_q == $past(ir_q[ADDR_W-1:0]))); // R8
    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && dec.branch && !take) |=> (pc_q == $past(pc_q))); // R9
    AST_UNDEF_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && dec.undef) |-> (!mem_wr && !mem_rd) ##1 $stable(acc_q)); // R14

endmodule

// File: tb/test_acc_cpu_core.sv
`timescale 1ns/1ps
module test_acc_cpu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd;
    logic        mem_wr;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] mem [4096];
    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always #2.5 clk = ~clk;

    acc_cpu_core i_acc_cpu_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // Synchronous memory model, one cycle read latency
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            finish_run();
        end
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    // Reset the core, run until halted; returns count of write cycles
    task automatic run_prog(output int writes);
        writes = 0;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int c = 0; c < 800; c++) begin
            @(negedge clk);
            if (mem_wr) writes++;
            if (halted) break;
        end
        check(halted, "R2 halt reached", {15'd0, halted}, 16'h0001);
    endtask

    task automatic t_reset();
        int w;
        clear_mem();
        mem[0] = ins(4'h1, 12'h123);
        mem[1] = 16'h0000;
        run_prog(w);
        clear_mem();
        mem[0] = ins(4'h4, 12'h100);
        mem[1] = 16'h0000;
        mem[12'h100] = 16'hFFFF;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check(mem_rd && !mem_wr && !halted, "R1 first cycle strobes",
              {13'd0, mem_rd, mem_wr, halted}, 16'h0004);
        check(mem_addr == 12'h000, "R1 first fetch address", {4'd0, mem_addr}, 16'h0000);
        for (int c = 0; c < 50; c++) begin
            @(negedge clk);
            if (halted) break;
        end
        check(mem[12'h100] == 16'h0000, "R1 accumulator cleared", mem[12'h100], 16'h0000);
    endtask

    task automatic t_halt();
        int w;
        bit quiet = 1'b1;
        clear_mem();
        mem[0] = ins(4'h1, 12'h005);
        mem[1] = ins(4'h4, 12'h100);
        mem[2] = 16'h0000;
        mem[3] = ins(4'h1, 12'h007);
        mem[4] = ins(4'h4, 12'h100);
        run_prog(w);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || !halted) quiet = 1'b0;
        end
        check(quiet, "R2 idle and halted after halt", {15'd0, quiet}, 16'h0001);
        check(mem[12'h100] == 16'h0005, "R2 nothing after halt", mem[12'h100], 16'h0005);
    endtask

    task automatic t_negate();
        int w;
        clear_mem();
        mem[12'h110] = 16'h8000;
        mem[0]  = ins(4'h1, 12'h123);
        mem[1]  = 16'h0001;
        mem[2]  = ins(4'h4, 12'h100);
        mem[3]  = ins(4'h1, 12'h800);
        mem[4]  = 16'h0001;
        mem[5]  = ins(4'h4, 12'h101);
        mem[6]  = ins(4'h1, 12'h000);
        mem[7]  = 16'h0001;
        mem[8]  = ins(4'h4, 12'h102);
        mem[9]  = ins(4'h2, 12'h110);
        mem[10] = 16'h0001;
        mem[11] = ins(4'h4, 12'h103);
        mem[12] = 16'h0000;
        run_prog(w);
        check(mem[12'h100] == 16'hFEDD, "R3 negate positive", mem[12'h100], 16'hFEDD);
        check(mem[12'h101] == 16'h0800, "R3 negate negative", mem[12'h101], 16'h0800);
        check(mem[12'h102] == 16'h0000, "R3 negate zero", mem[12'h102], 16'h0000);
        check(mem[12'h103] == 16'h8000, "R3 negate most negative", mem[12'h103], 16'h8000);
    endtask

    task automatic t_imm();
        int w;
        clear_mem();
        mem[0] = ins(4'h1, 12'h7FF);
        mem[1] = ins(4'h4, 12'h100);
        mem[2] = ins(4'h1, 12'hFFF);
        mem[3] = ins(4'h4, 12'h101);
        mem[4] = ins(4'h1, 12'h800);
        mem[5] = ins(4'h4, 12'h102);
        mem[6] = 16'h0000;
        run_prog(w);
        check(mem[12'h100] == 16'h07FF, "R4 largest positive immediate", mem[12'h100], 16'h07FF);
        check(mem[12'h101] == 16'hFFFF, "R4 immediate minus one", mem[12'h101], 16'hFFFF);
        check(mem[12'h102] == 16'hF800, "R4 most negative immediate", mem[12'h102], 16'hF800);
    endtask

    task automatic t_direct();
        int w;
        clear_mem();
        mem[12'h110] = 16'hBEEF;
        mem[0] = ins(4'h2, 12'h110);
        mem[1] = ins(4'h4, 12'h120);
        mem[2] = 16'h0000;
        run_prog(w);
        check(mem[12'h120] == 16'hBEEF, "R5 direct load and store", mem[12'h120], 16'hBEEF);
        check(mem[12'h110] == 16'hBEEF && w == 1, "R5 single write, source intact",
              mem[12'h110], 16'hBEEF);
    endtask

    task automatic t_indirect_load();
        int w;
        clear_mem();
        mem[12'h110] = 16'h0150;
        mem[12'h111] = 16'hF152;
        mem[12'h150] = 16'h1234;
        mem[12'h152] = 16'h4321;
        mem[0] = ins(4'h3, 12'h110);
        mem[1] = ins(4'h4, 12'h120);
        mem[2] = ins(4'h3, 12'h111);
        mem[3] = ins(4'h4, 12'h121);
        mem[4] = 16'h0000;
        run_prog(w);
        check(mem[12'h120] == 16'h1234, "R6 indirect load", mem[12'h120], 16'h1234);
        check(mem[12'h121] == 16'h4321, "R6 pointer upper bits ignored", mem[12'h121], 16'h4321);
    endtask

    task automatic t_indirect_store();
        int w;
        clear_mem();
        mem[12'h110] = 16'hA160;
        mem[0] = ins(4'h1, 12'h055);
        mem[1] = ins(4'h5, 12'h110);
        mem[2] = 16'h0000;
        run_prog(w);
        check(mem[12'h160] == 16'h0055, "R7 indirect store target", mem[12'h160], 16'h0055);
        check(mem[12'h110] == 16'hA160 && w == 1, "R7 pointer unchanged", mem[12'h110], 16'hA160);
    endtask

    task automatic t_jump();
        int w;
        clear_mem();
        mem[0] = ins(4'h6, 12'h010);
        mem[1] = ins(4'h1, 12'h001);
        mem[2] = ins(4'h4, 12'h100);
        mem[3] = 16'h0000;
        mem[12'h010] = ins(4'h1, 12'h002);
        mem[12'h011] = ins(4'h4, 12'h100);
        mem[12'h012] = 16'h0000;
        run_prog(w);
        check(mem[12'h100] == 16'h0002, "R8 unconditional jump", mem[12'h100], 16'h0002);
    endtask

    // Conditional branch with a loaded accumulator value; result 2 if taken, 1 if not
    task automatic t_cond(input logic [3:0] op, input logic [15:0] val, input bit taken,
                          input string req);
        int w;
        logic [15:0] exp;
        clear_mem();
        mem[12'h110] = val;
        mem[0] = ins(4'h2, 12'h110);
        mem[1] = ins(op, 12'h020);
        mem[2] = ins(4'h1, 12'h001);
        mem[3] = ins(4'h4, 12'h100);
        mem[4] = 16'h0000;
        mem[12'h020] = ins(4'h1, 12'h002);
        mem[12'h021] = ins(4'h4, 12'h100);
        mem[12'h022] = 16'h0000;
        run_prog(w);
        exp = taken ? 16'h0002 : 16'h0001;
        check(mem[12'h100] == exp, req, mem[12'h100], exp);
    endtask

    task automatic t_add();
        int w;
        clear_mem();
        mem[12'h110] = 16'h7FFF;
        mem[12'h111] = 16'h0001;
        mem[12'h112] = 16'hFFFF;
        mem[12'h113] = 16'h0003;
        mem[0] = ins(4'h2, 12'h110);
        mem[1] = ins(4'hA, 12'h111);
        mem[2] = ins(4'h4, 12'h100);
        mem[3] = ins(4'h2, 12'h112);
        mem[4] = ins(4'hA, 12'h113);
        mem[5] = ins(4'h4, 12'h101);
        mem[6] = 16'h0000;
        run_prog(w);
        check(mem[12'h100] == 16'h8000, "R12 add across sign", mem[12'h100], 16'h8000);
        check(mem[12'h101] == 16'h0002, "R12 add wraps", mem[12'h101], 16'h0002);
    endtask

    task automatic t_and();
        int w;
        clear_mem();
        mem[12'h110] = 16'hF0F0;
        mem[12'h111] = 16'h3C3C;
        mem[0] = ins(4'h2, 12'h110);
        mem[1] = ins(4'hD, 12'h111);
        mem[2] = ins(4'h4, 12'h100);
        mem[3] = 16'h0000;
        run_prog(w);
        check(mem[12'h100] == 16'h3030, "R13 bitwise and", mem[12'h100], 16'h3030);
    endtask

    task automatic t_undef();
        int w;
        clear_mem();
        mem[0] = ins(4'h1, 12'h02A);
        mem[1] = 16'hB123;
        mem[2] = 16'hC456;
        mem[3] = 16'hE789;
        mem[4] = 16'hF000;
        mem[5] = 16'h0002;
        mem[6] = 16'h0FFF;
        mem[7] = ins(4'h4, 12'h100);
        mem[8] = 16'h0000;
        run_prog(w);
        check(mem[12'h100] == 16'h002A, "R14 accumulator kept", mem[12'h100], 16'h002A);
        check(w == 1, "R14 no extra writes", 16'(w), 16'h0001);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_halt();
        t_negate();
        t_imm();
        t_direct();
        t_indirect_load();
        t_indirect_store();
        t_jump();
        t_cond(4'h7, 16'h0000, 1'b1, "R9 zero taken");
        t_cond(4'h7, 16'h0001, 1'b0, "R9 one not taken");
        t_cond(4'h7, 16'h8000, 1'b0, "R9 negative not taken");
        t_cond(4'h8, 16'h0001, 1'b1, "R10 one taken");
        t_cond(4'h8, 16'h7FFF, 1'b1, "R10 max positive taken");
        t_cond(4'h8, 16'h0000, 1'b0, "R10 zero not taken");
        t_cond(4'h8, 16'h8000, 1'b0, "R10 negative not taken");
        t_cond(4'h9, 16'h8000, 1'b1, "R11 most negative taken");
        t_cond(4'h9, 16'hFFFF, 1'b1, "R11 minus one taken");
        t_cond(4'h9, 16'h0000, 1'b0, "R11 zero not taken");
        t_cond(4'h9, 16'h7FFF, 1'b0, "R11 positive not taken");
        t_add();
        t_and();
        t_undef();
        finish_run();
    end

endmodule